// File: doc/BRIEF.md
# Reset Source and Start-up Timer Sequencer

This block decides when a processor core may leave reset and where it resumes. It merges four reset sources (power-on, brown-out, external master clear, watchdog timeout) with two wake sources from sleep (watchdog timeout, interrupt). After a supply event it runs a power-up timer and an oscillator start-up counter side by side, and it holds the core in reset until both have reached their limits. The power-up timer counts ticks of a slow timebase. The oscillator counter counts rising edges of the oscillator input.

A wake from sleep never resets the core. The crystal oscillator modes first halt the core for the oscillator start-up count. The external-clock and RC modes resume on the next cycle. Each release presents a program counter value for one cycle: zero after a reset, or the sleeping instruction's address plus one after a wake. An interrupt wake with interrupts enabled also raises a flag that tells the core to take the interrupt vector after that next instruction. A four-bit cause code records what happened last.

Top module: `rstseq_top`

## Requirements
- R1: While `por_req` is high, `core_rst` is 1 and `rst_cause` is 4'b1100 (bit3 = no watchdog timeout, bit2 = not powered down, bit1 = not power-on, bit0 = not brown-out). After it drops, reset is released only when PWRT_TICKS slow ticks and OST_EDGES oscillator rising edges have both been counted. This holds in every `osc_mode` (00 LF, 01 XT, 10 EC, 11 RC).
- R2: While `bor_req` is high, `core_rst` is 1 and `rst_cause` is 4'b1110. A new brown-out during the start-up wait clears both counts, and both counts start again from zero when `bor_req` drops.
- R3: Neither counter advances while a power-on or brown-out request is high. The oscillator counter counts rising edges only, so an input held high counts once.
- R4: A master clear holds `core_rst` for as long as it is high, including during a start-up wait. Once no start-up wait is pending, reset releases on the first cycle after the request drops. The cause is 4'b1111 when the core is awake and 4'b1011 when the core is asleep or waiting on the wake delay.
- R5: A watchdog timeout while awake gives a single-cycle reset with cause 4'b0111.
- R6: A watchdog timeout while asleep wakes the core without a reset and sets the cause to 4'b0011.
- R7: On a wake, osc_mode 00/01 asserts `core_halt` until OST_EDGES oscillator edges have been counted. osc_mode 10/11 resumes with no halt.
- R8: Every release raises `pc_load_en` for exactly one cycle. `pc_load` is 0 after a reset and `cur_pc`+1 (modulo 2^PC_W, captured at the wake) after a wake.
- R9: `take_irq` accompanies the wake release only for an interrupt wake with `gie_disable` = 0. It is never raised for a watchdog wake.
- R10: `wake_irq` while not sleeping has no effect. An interrupt wake leaves `rst_cause` unchanged.
- R11: Priority runs power-on over brown-out over master clear over watchdog. `core_rst` and `core_halt` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| por_req | input | 1 | Power-on request, active high; also the block's reset |
| bor_req | input | 1 | Brown-out request, high while supply is low |
| mclr_req | input | 1 | External master clear, active high level |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| sleeping | input | 1 | Core is in sleep |
| wake_irq | input | 1 | Interrupt wake request |
| gie_disable | input | 1 | Global interrupt disable (1 = disabled) |
| osc_mode | input | 2 | 00 LF, 01 XT, 10 EC, 11 RC |
| osc_in | input | 1 | Oscillator input sampled for rising edges |
| slow_tick | input | 1 | Slow timebase tick for the power-up timer |
| cur_pc | input | PC_W | Core program counter at the sleep instruction |
| core_rst | output | 1 | Internal reset to the core |
| core_halt | output | 1 | Core stalled during the wake oscillator delay |
| rst_cause | output | 4 | Cause code {no-timeout, awake, not-power-on, not-brown-out} |
| pc_load_en | output | 1 | One-cycle strobe to load `pc_load` |
| pc_load | output | PC_W | Program counter value to resume at |
| take_irq | output | 1 | Take the interrupt vector after the next instruction |

## Verification
The power-on wait is swept over all four oscillator modes, each time finishing the oscillator edges before the last tick. This shows that the longer of the two timers sets the release and that no mode skips the wait. Separate runs finish ticks before edges, hold the oscillator input high for several cycles, and re-trigger a brown-out mid-wait. These tell edge counting apart from level counting and a true restart apart from a paused count. Wakes are swept over the four modes and both interrupt-enable settings, and `cur_pc` = FFFFh checks the wrap. Combined requests and a master clear that outlasts the timers show the priority order and the reset extension.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_HOLD   = 2'd1,
      ST_EXTRST = 2'd2,
      ST_XWAKE  = 2'd3
   } seq_state_t;

   // cause bits: {no_timeout, awake, not_power_on, not_brown_out}
   localparam logic [3:0] CAUSE_PWRON   = 4'b1100;
   localparam logic [3:0] CAUSE_BROWN   = 4'b1110;
   localparam logic [3:0] CAUSE_EXT_RUN = 4'b1111;
   localparam logic [3:0] CAUSE_EXT_SLP = 4'b1011;
   localparam logic [3:0] CAUSE_WDT_RUN = 4'b0111;
   localparam logic [3:0] CAUSE_WDT_SLP = 4'b0011;

   // modes 00 and 01 drive a crystal and need the start-up count on wake
   function automatic logic crystal_mode(input logic [1:0] mode);
      return ~mode[1];
   endfunction
endpackage

// File: rtl/rstseq_satcnt.sv
module rstseq_satcnt #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic clr,
   input  logic inc,
   output logic done
);
   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT == 1) begin : g_flag
         logic hit_q;
         always_ff @(posedge clk) begin
            if (clr)      hit_q <= 1'b0;
            else if (inc) hit_q <= 1'b1;
         end
         assign done = hit_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (clr)               cnt_q <= '0;
            else if (inc && !done) cnt_q <= cnt_q + 1'b1;
         end
         assign done = (cnt_q == CW'(LIMIT));
      end
   endgenerate
endmodule

// File: rtl/rstseq_rise.sv
module rstseq_rise #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic sig_in,
   output logic rise
);
   logic sig_s;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sig_s = sig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], sig_in} >> 0;
         end
         assign sig_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) prev_q <= sig_s;
   assign rise = sig_s & ~prev_q;
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int unsigned PC_W = 16
) (
   input  logic            clk,
   input  logic            por_req,
   input  logic            bor_req,
   input  logic            mclr_req,
   input  logic            wdt_timeout,
   input  logic            sleeping,
   input  logic            wake_irq,
   input  logic            gie_disable,
   input  logic [1:0]      osc_mode,
   input  logic [PC_W-1:0] cur_pc,
   input  logic            pwrt_done,
   input  logic            ost_done,
   output logic            clr_all,
   output logic            clr_ost,
   output logic            pwrt_run,
   output logic            ost_run,
   output logic            core_rst,
   output logic            core_halt,
   output logic [3:0]      rst_cause,
   output logic            pc_load_en,
   output logic [PC_W-1:0] pc_load,
   output logic            take_irq
);
   seq_state_t      state_q, state_d;
   logic [3:0]      cause_q, cause_d;
   logic [PC_W-1:0] pc_q, pc_d;
   logic            ld_q, ld_d, irq_q, irq_d, pend_q, pend_d;
   logic            irq_wants;

   assign irq_wants = wake_irq & ~wdt_timeout & ~gie_disable;

   always_comb begin
      state_d = state_q;
      cause_d = cause_q;
      pc_d    = pc_q;
      pend_d  = pend_q;
      ld_d    = 1'b0;
      irq_d   = 1'b0;
      clr_all = 1'b0;
      clr_ost = 1'b0;
      if (por_req) begin
         state_d = ST_HOLD;
         cause_d = CAUSE_PWRON;
         pend_d  = 1'b0;
         clr_all = 1'b1;
      end else if (bor_req) begin
         state_d = ST_HOLD;
         cause_d = CAUSE_BROWN;
         pend_d  = 1'b0;
         clr_all = 1'b1;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (mclr_req) begin
                  state_d = ST_EXTRST;
                  cause_d = sleeping ? CAUSE_EXT_SLP : CAUSE_EXT_RUN;
               end else if (wdt_timeout && !sleeping) begin
                  state_d = ST_EXTRST;
                  cause_d = CAUSE_WDT_RUN;
               end else if (sleeping && (wdt_timeout || wake_irq)) begin
                  if (wdt_timeout) cause_d = CAUSE_WDT_SLP;
                  pc_d = cur_pc + PC_W'(1);
                  if (crystal_mode(osc_mode)) begin
                     state_d = ST_XWAKE;
                     clr_ost = 1'b1;
                     pend_d  = irq_wants;
                  end else begin
                     ld_d  = 1'b1;
                     irq_d = irq_wants;
                  end
               end
            end
            ST_HOLD: begin
               if (pwrt_done && ost_done && !mclr_req) begin
                  state_d = ST_RUN;
                  ld_d    = 1'b1;
                  pc_d    = '0;
               end
            end
            ST_EXTRST: begin
               if (!mclr_req) begin
                  state_d = ST_RUN;
                  ld_d    = 1'b1;
                  pc_d    = '0;
               end
            end
            ST_XWAKE: begin
               if (mclr_req) begin
                  state_d = ST_EXTRST;
                  cause_d = CAUSE_EXT_SLP;
                  pend_d  = 1'b0;
               end else if (ost_done) begin
                  state_d = ST_RUN;
                  ld_d    = 1'b1;
                  irq_d   = pend_q;
                  pend_d  = 1'b0;
               end
            end
            default: state_d = ST_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      state_q <= state_d;
      cause_q <= cause_d;
      pc_q    <= pc_d;
      pend_q  <= pend_d;
      ld_q    <= ld_d;
      irq_q   <= irq_d;
   end

   assign pwrt_run   = (state_q == ST_HOLD);
   assign ost_run    = (state_q == ST_HOLD) || (state_q == ST_XWAKE);
   assign core_rst   = (state_q == ST_HOLD) || (state_q == ST_EXTRST);
   assign core_halt  = (state_q == ST_XWAKE);
   assign rst_cause  = cause_q;
   assign pc_load_en = ld_q;
   assign pc_load    = pc_q;
   assign take_irq   = irq_q;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
   parameter int unsigned PC_W        = 16,
   parameter int unsigned PWRT_TICKS  = 96,
   parameter int unsigned OST_EDGES   = 1024,
   parameter int unsigned OSC_SYNC    = 0
) (
   input  logic            clk,
   input  logic            por_req,
   input  logic            bor_req,
   input  logic            mclr_req,
   input  logic            wdt_timeout,
   input  logic            sleeping,
   input  logic            wake_irq,
   input  logic            gie_disable,
   input  logic [1:0]      osc_mode,
   input  logic            osc_in,
   input  logic            slow_tick,
   input  logic [PC_W-1:0] cur_pc,
   output logic            core_rst,
   output logic            core_halt,
   output logic [3:0]      rst_cause,
   output logic            pc_load_en,
   output logic [PC_W-1:0] pc_load,
   output logic            take_irq
);
   generate
      if (PC_W < 2)        $error("rstseq_top: PC_W must be at least 2");
      if (PWRT_TICKS < 1)  $error("rstseq_top: PWRT_TICKS must be at least 1");
      if (OST_EDGES < 1)   $error("rstseq_top: OST_EDGES must be at least 1");
      if (OSC_SYNC == 1)   $error("rstseq_top: OSC_SYNC must be 0 or at least 2");
   endgenerate

   logic osc_rise;
   logic pwrt_done, ost_done;
   logic clr_all, clr_ost, pwrt_run, ost_run;

   rstseq_rise #(.SYNC_STAGES(OSC_SYNC)) i_rise (
      .clk    (clk),
      .sig_in (osc_in),
      .rise   (osc_rise)
   );

   rstseq_satcnt #(.LIMIT(PWRT_TICKS)) i_pwrt (
      .clk  (clk),
      .clr  (clr_all),
      .inc  (pwrt_run & slow_tick),
      .done (pwrt_done)
   );

   rstseq_satcnt #(.LIMIT(OST_EDGES)) i_ost (
      .clk  (clk),
      .clr  (clr_all | clr_ost),
      .inc  (ost_run & osc_rise),
      .done (ost_done)
   );

   rstseq_ctrl #(.PC_W(PC_W)) i_ctrl (
      .clk         (clk),
      .por_req     (por_req),
      .bor_req     (bor_req),
      .mclr_req    (mclr_req),
      .wdt_timeout (wdt_timeout),
      .sleeping    (sleeping),
      .wake_irq    (wake_irq),
      .gie_disable (gie_disable),
      .osc_mode    (osc_mode),
      .cur_pc      (cur_pc),
      .pwrt_done   (pwrt_done),
      .ost_done    (ost_done),
      .clr_all     (clr_all),
      .clr_ost     (clr_ost),
      .pwrt_run    (pwrt_run),
      .ost_run     (ost_run),
      .core_rst    (core_rst),
      .core_halt   (core_halt),
      .rst_cause   (rst_cause),
      .pc_load_en  (pc_load_en),
      .pc_load     (pc_load),
      .take_irq    (take_irq)
   );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
   parameter int unsigned PC_W = 16
) (
   input logic            clk,
   input logic            por_req,
   input logic            bor_req,
   input logic            mclr_req,
   input logic            core_rst,
   input logic            core_halt,
   input logic [3:0]      rst_cause,
   input logic            pc_load_en,
   input logic [PC_W-1:0] pc_load,
   input logic            take_irq
);
   a_r11_rst_halt_excl: assert property (@(posedge clk) disable iff (por_req)
      !(core_rst && core_halt));

   a_r2_brownout_holds: assert property (@(posedge clk) disable iff (por_req)
      bor_req |=> core_rst && rst_cause == 4'b1110);

   a_r4_mclr_holds: assert property (@(posedge clk) disable iff (por_req)
      mclr_req |=> core_rst);

   a_r8_release_loads_zero: assert property (@(posedge clk) disable iff (por_req)
      $fell(core_rst) |-> pc_load_en && pc_load == '0);

   a_r7_halt_release_loads: assert property (@(posedge clk) disable iff (por_req)
      $fell(core_halt) && !core_rst |-> pc_load_en);

   a_r9_irq_with_load: assert property (@(posedge clk) disable iff (por_req)
      take_irq |-> pc_load_en && !core_rst && !core_halt);
endmodule

bind rstseq_top rstseq_chk #(.PC_W(PC_W)) i_chk (
   .clk        (clk),
   .por_req    (por_req),
   .bor_req    (bor_req),
   .mclr_req   (mclr_req),
   .core_rst   (core_rst),
   .core_halt  (core_halt),
   .rst_cause  (rst_cause),
   .pc_load_en (pc_load_en),
   .pc_load    (pc_load),
   .take_irq   (take_irq)
);

// File: tb/test_rstseq_top.sv
module test_rstseq_top;
   localparam int PC_W = 16;
   localparam int TK   = 6;
   localparam int OE   = 32;

   logic clk = 1'b0;
   logic por_req = 1'b1, bor_req = 1'b0, mclr_req = 1'b0, wdt_timeout = 1'b0;
   logic sleeping = 1'b0, wake_irq = 1'b0, gie_disable = 1'b0;
   logic [1:0] osc_mode = 2'b01;
   logic osc_in = 1'b0, slow_tick = 1'b0;
   logic [PC_W-1:0] cur_pc = 16'h1234;
   logic core_rst, core_halt, pc_load_en, take_irq;
   logic [3:0] rst_cause;
   logic [PC_W-1:0] pc_load;
   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   rstseq_top #(.PC_W(PC_W), .PWRT_TICKS(TK), .OST_EDGES(OE)) i_rstseq_top (.*);

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic osc_pulse(input int n);
      repeat (n) begin osc_in = 1'b1; cyc(1); osc_in = 1'b0; cyc(1); end
   endtask

   task automatic tick(input int n);
      repeat (n) begin slow_tick = 1'b1; cyc(1); slow_tick = 1'b0; cyc(1); end
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic power_up;
      por_req = 1'b1; cyc(2); por_req = 1'b0; cyc(1);
      tick(TK); osc_pulse(OE);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      cyc(3);
      chk("R1 reset rst", core_rst, 1);
      chk("R1 reset cause", rst_cause, 4'b1100);
      chk("R11 reset halt", core_halt, 0);
      // R3: counts during the request are discarded
      osc_pulse(40); tick(10);
      chk("R3 still held", core_rst, 1);
      por_req = 1'b0; cyc(1);
      tick(TK); osc_pulse(OE - 1);
      chk("R1 edges short", core_rst, 1);
      osc_pulse(1);
      chk("R1 released", core_rst, 0);
      chk("R8 load strobe", pc_load_en, 1);
      chk("R8 load zero", pc_load, 0);
      cyc(1);
      chk("R8 one cycle", pc_load_en, 0);

      // R1: every oscillator mode waits for both timers
      for (int m = 0; m < 4; m++) begin
         osc_mode = 2'(m);
         por_req = 1'b1; cyc(2); por_req = 1'b0; cyc(1);
         osc_pulse(OE); tick(TK - 1);
         chk("R1 mode ticks short", core_rst, 1);
         tick(1);
         chk("R1 mode release", core_rst, 0);
         chk("R1 mode cause", rst_cause, 4'b1100);
      end

      // R3: level held high counts once
      por_req = 1'b1; cyc(2); por_req = 1'b0; cyc(1);
      tick(TK);
      osc_in = 1'b1; cyc(10); osc_in = 1'b0; cyc(1);
      osc_pulse(OE - 2);
      chk("R3 level once", core_rst, 1);
      osc_pulse(1);
      chk("R3 final edge", core_rst, 0);

      // R2: brown-out restarts both timers
      bor_req = 1'b1; cyc(2);
      chk("R2 rst", core_rst, 1);
      chk("R2 cause", rst_cause, 4'b1110);
      bor_req = 1'b0; cyc(1);
      tick(4); osc_pulse(20);
      bor_req = 1'b1; cyc(1); bor_req = 1'b0; cyc(1);
      tick(TK - 1); osc_pulse(OE);
      chk("R2 restarted", core_rst, 1);
      tick(1);
      chk("R2 release", core_rst, 0);
      chk("R2 cause kept", rst_cause, 4'b1110);

      // R11 priority, R4 extension of start-up wait
      bor_req = 1'b1; mclr_req = 1'b1; cyc(2);
      chk("R11 bor over mclr", rst_cause, 4'b1110);
      por_req = 1'b1; cyc(1);
      chk("R11 por over bor", rst_cause, 4'b1100);
      por_req = 1'b0; bor_req = 1'b0; cyc(1);
      tick(TK); osc_pulse(OE); cyc(2);
      chk("R4 mclr extends", core_rst, 1);
      mclr_req = 1'b0; cyc(1);
      chk("R4 ext release", core_rst, 0);
      chk("R4 cause stays", rst_cause, 4'b1100);

      // R4 master clear awake / asleep
      mclr_req = 1'b1; cyc(3);
      chk("R4 held", core_rst, 1);
      chk("R4 cause awake", rst_cause, 4'b1111);
      mclr_req = 1'b0; cyc(1);
      chk("R4 no delay", core_rst, 0);
      chk("R8 mclr load", pc_load_en, 1);
      sleeping = 1'b1; mclr_req = 1'b1; cyc(1);
      sleeping = 1'b0;
      chk("R4 cause asleep", rst_cause, 4'b1011);
      mclr_req = 1'b0; cyc(1);
      chk("R4 sleep release", core_rst, 0);

      // R5 watchdog while awake
      wdt_timeout = 1'b1; cyc(1); wdt_timeout = 1'b0;
      chk("R5 rst", core_rst, 1);
      chk("R5 cause", rst_cause, 4'b0111);
      cyc(1);
      chk("R5 one cycle", core_rst, 0);
      chk("R5 load zero", pc_load, 0);

      // R6 watchdog wake in XT
      osc_mode = 2'b01; cur_pc = 16'h0100; sleeping = 1'b1;
      wdt_timeout = 1'b1; cyc(1); wdt_timeout = 1'b0; sleeping = 1'b0;
      chk("R6 no reset", core_rst, 0);
      chk("R6 cause", rst_cause, 4'b0011);
      chk("R7 halted", core_halt, 1);
      osc_pulse(OE - 1);
      chk("R7 still halted", core_halt, 1);
      osc_pulse(1);
      chk("R7 resumed", core_halt, 0);
      chk("R8 wake load", pc_load_en, 1);
      chk("R8 wake pc", pc_load, 16'h0101);
      chk("R9 wdt no irq", take_irq, 0);
      cyc(1);

      // R7/R9/R10 interrupt wake over modes and enable settings
      for (int m = 0; m < 4; m++) begin
         for (int g = 0; g < 2; g++) begin
            osc_mode = 2'(m); gie_disable = g[0];
            cur_pc = (m == 3) ? 16'hFFFF : 16'(16'h2AA0 + m * 2 + g);
            sleeping = 1'b1; wake_irq = 1'b1; cyc(1);
            wake_irq = 1'b0; sleeping = 1'b0;
            chk("R7 halt by mode", core_halt, (m < 2) ? 1 : 0);
            if (m < 2) osc_pulse(OE);
            chk("R8 irq wake load", pc_load_en, 1);
            chk("R8 irq wake pc", pc_load, (m == 3) ? 0 : 16'(16'h2AA1 + m * 2 + g));
            chk("R9 take irq", take_irq, (g == 0) ? 1 : 0);
            chk("R10 cause unchanged", rst_cause, 4'b0011);
            cyc(1);
         end
      end

      // R10 interrupt while awake ignored
      gie_disable = 1'b0; wake_irq = 1'b1; cyc(1); wake_irq = 1'b0;
      chk("R10 no load", pc_load_en, 0);
      chk("R10 no halt", core_halt, 0);
      chk("R10 no reset", core_rst, 0);
      cyc(2);
      finish_run();
   end
endmodule